// File: doc/BRIEF.md
# Hysteretic Frequency Lock Controller

This block decides whether a receive PLL should follow the incoming serial data or fall back to the local reference clock. Each measurement is a signed frequency offset in ppm between the recovered clock and the reference, marked by a strobe. The block classifies the magnitude of that offset against two pairs of thresholds. The pair it uses depends on whether it is currently locked. A band between the two thresholds of each pair keeps the present state, which gives the decision hysteresis.

A separate run-length fail flag overrides the frequency test and drops the block out of lock. The flag comes from a checker that looks for overly long runs of identical bits. The block drives a lock-state output and a registered select bit that chooses the PLL reference source. It does not measure the offset itself, and it does not switch clocks.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset, `locked_o` is 0 and `sel_data_o` is 0, which selects the reference clock.
- R2: While `meas_valid` is 0 and `runlen_fail` is 0, both outputs keep their values across the clock edge.
- R3: In the unlocked state, a valid measurement with magnitude below 244 ppm and `runlen_fail` at 0 makes `locked_o` 1 after that clock edge.
- R4: In the unlocked state, a valid measurement with magnitude from 244 to 366 ppm inclusive leaves the block unlocked.
- R5: In the unlocked state, a valid measurement with magnitude above 366 ppm leaves the block unlocked.
- R6: In the locked state, a valid measurement with magnitude below 488 ppm and `runlen_fail` at 0 keeps the block locked.
- R7: In the locked state, a valid measurement with magnitude from 488 to 732 ppm inclusive keeps the present state, so the block stays locked.
- R8: In the locked state, a valid measurement with magnitude above 732 ppm makes `locked_o` 0 after that clock edge.
- R9: `meas_ppm` is two's complement, and only its magnitude is compared. A negative offset acts like the positive offset of the same size, and the most negative code counts as a magnitude of 2^(W-1).
- R10: When `runlen_fail` is 1 on a clock edge, `locked_o` is 0 after that edge, whatever the values of `meas_valid` and `meas_ppm`. Locking therefore needs both tests to pass.
- R11: After every clock edge, `sel_data_o` equals `locked_o`. A value of 1 selects the recovered data clock and a value of 0 selects the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Strobe marking a new offset measurement |
| meas_ppm | input | W (16) | Signed offset in ppm, two's complement |
| runlen_fail | input | 1 | Run-length check failed |
| locked_o | output | 1 | Lock state, 1 = locked |
| sel_data_o | output | 1 | PLL reference select, 1 = data, 0 = reference clock |

## Verification
The bench steps both directions through every threshold edge: 243, 244, 366 and 367 while unlocked, and 487, 488, 732 and 733 while locked. A design that uses the wrong comparison, or the wrong pair of thresholds for the present state, would lock or unlock one code away from the intended point. Negative offsets, including the most negative code, catch a design that compares the raw signed value: it would lock on a large negative offset. Cycles with the strobe low, and run-length failures with and without a strobe, catch a design that updates without a measurement or lets the frequency test override a run-length failure.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    // Outcome of comparing an offset magnitude with one threshold pair
    typedef enum logic [1:0] {
        ZONE_ACQ  = 2'd0,   // inside the tight limit: lock or keep lock
        ZONE_HOLD = 2'd1,   // between the limits: keep the present state
        ZONE_DROP = 2'd2    // outside the wide limit: unlock
    } zone_e;

    typedef struct packed {
        logic locked;
        logic sel_data;
    } lfc_state_t;

endpackage

// File: rtl/lfc_abs.sv
module lfc_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // The most negative code maps to 2^(W-1), which still fits unsigned
    always_comb begin
        if (val[W-1]) mag = (~val) + ONE;
        else          mag = val;
    end
endmodule

// File: rtl/lfc_band.sv
module lfc_band
    import lfc_pkg::*;
#(
    parameter int W  = 16,
    parameter int LO = 244,
    parameter int HI = 366
) (
    input  logic [W-1:0] mag,
    output zone_e        zone
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (mag < LO_V)      zone = ZONE_ACQ;
        else if (mag > HI_V) zone = ZONE_DROP;
        else                 zone = ZONE_HOLD;
    end
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
    import lfc_pkg::*;
#(
    parameter int W         = 16,
    parameter int KEEP_LO   = 488,  // locked: below keeps lock
    parameter int KEEP_HI   = 732,  // locked: above drops lock
    parameter int ACQ_LO    = 244,  // unlocked: below acquires lock
    parameter int ACQ_HI    = 366   // unlocked: above stays out
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         meas_valid,
    input  logic [W-1:0] meas_ppm,
    input  logic         runlen_fail,
    output logic         locked_o,
    output logic         sel_data_o
);
    logic [W-1:0] mag;
    zone_e        zone_keep;
    zone_e        zone_acq;
    zone_e        zone_sel;
    lfc_state_t   st_d, st_q;

    lfc_abs #(.W(W)) u_abs (
        .val (meas_ppm),
        .mag (mag)
    );

    // Threshold pair applied while locked
    lfc_band #(.W(W), .LO(KEEP_LO), .HI(KEEP_HI)) u_band_keep (
        .mag  (mag),
        .zone (zone_keep)
    );

    // Threshold pair applied while unlocked
    lfc_band #(.W(W), .LO(ACQ_LO), .HI(ACQ_HI)) u_band_acq (
        .mag  (mag),
        .zone (zone_acq)
    );

    always_comb begin
        zone_sel = st_q.locked ? zone_keep : zone_acq;
        st_d     = st_q;
        if (runlen_fail) begin
            st_d.locked = 1'b0;
        end else if (meas_valid) begin
            case (zone_sel)
                ZONE_ACQ:  st_d.locked = 1'b1;
                ZONE_DROP: st_d.locked = 1'b0;
                default:   st_d.locked = st_q.locked;
            endcase
        end
        st_d.sel_data = st_d.locked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o   = st_q.locked;
    assign sel_data_o = st_q.sel_data;
endmodule

// File: rtl/freq_lock_ctrl_chk.sv
module freq_lock_ctrl_chk #(
    parameter int W       = 16,
    parameter int KEEP_LO = 488,
    parameter int KEEP_HI = 732,
    parameter int ACQ_LO  = 244,
    parameter int ACQ_HI  = 366
) (
    input logic         clk,
    input logic         rst_n,
    input logic         meas_valid,
    input logic [W-1:0] meas_ppm,
    input logic         runlen_fail,
    input logic         locked_o,
    input logic         sel_data_o
);
    logic [W:0] m;
    assign m = meas_ppm[W-1] ? ({1'b0, ~meas_ppm} + 1'b1) : {1'b0, meas_ppm};

    p_rl_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        runlen_fail |=> !locked_o);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !runlen_fail) |=> ($stable(locked_o) && $stable(sel_data_o)));

    p_sel_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_data_o == locked_o);

    p_acquire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && meas_valid && !runlen_fail && (m < (W+1)'(ACQ_LO))) |=> locked_o);

    p_stay_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && meas_valid && (m >= (W+1)'(ACQ_LO))) |=> !locked_o);

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && meas_valid && !runlen_fail && (m <= (W+1)'(KEEP_HI))) |=> locked_o);

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && meas_valid && (m > (W+1)'(KEEP_HI))) |=> !locked_o);
endmodule

bind freq_lock_ctrl freq_lock_ctrl_chk #(
    .W(W), .KEEP_LO(KEEP_LO), .KEEP_HI(KEEP_HI), .ACQ_LO(ACQ_LO), .ACQ_HI(ACQ_HI)
) u_chk (.*);

// File: tb/tb_freq_lock_ctrl.sv
module tb_freq_lock_ctrl;
    localparam int W      = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         meas_valid = 1'b0;
    logic [W-1:0] meas_ppm = '0;
    logic         runlen_fail = 1'b0;
    logic         locked_o, sel_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_lock = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_lock_ctrl dut (.*);

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Behavioural reference: decide from the requirement thresholds
    function automatic bit ref_next(bit cur, bit v, int ppm, bit rl);
        int a;
        a = (ppm < 0) ? -ppm : ppm;
        if (rl) return 0;
        if (!v) return cur;
        if (cur) begin
            if (a > 732) return 0;
            return 1;
        end
        if (a < 244) return 1;
        return 0;
    endfunction

    task automatic step(input string req, input bit v, input int ppm, input bit rl);
        meas_valid  = v;
        meas_ppm    = W'(ppm);
        runlen_fail = rl;
        @(posedge clk);
        model_lock = ref_next(model_lock, v, ppm, rl);
        @(negedge clk);
        check(req, locked_o, model_lock);
        check("R11", sel_data_o, model_lock);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", locked_o, 1'b0);
        check("R1", sel_data_o, 1'b0);
        rst_n = 1'b1;

        // unlocked edges
        step("R4", 1, 244, 0);
        step("R4", 1, 366, 0);
        step("R5", 1, 367, 0);
        step("R5", 1, -367, 0);
        step("R2", 0, 0, 0);
        step("R3", 1, 243, 0);
        // locked edges
        step("R6", 1, 487, 0);
        step("R7", 1, 488, 0);
        step("R7", 1, 732, 0);
        step("R7", 1, -732, 0);
        step("R2", 0, 5000, 0);
        step("R8", 1, 733, 0);
        // negative values
        step("R9", 1, -243, 0);
        step("R9", 1, -733, 0);
        step("R9", 1, -32768, 0);
        step("R3", 1, 0, 0);
        step("R9", 1, -32768, 0);
        // run-length fail
        step("R3", 1, 10, 0);
        step("R10", 0, 0, 1);
        step("R10", 1, 0, 1);
        step("R2", 0, 0, 0);
        step("R3", 1, -100, 0);
        step("R10", 1, 100, 1);

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int p;
            p = int'($urandom_range(0, 1000)) - 500;
            if ($urandom_range(0, 3) == 0) p = p * 2;
            step("R6", $urandom_range(0, 3) != 0, p, $urandom_range(0, 15) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule